// File: doc/BRIEF.md
# Deep-Color Packing Phase Tracker

This block follows the pixel packing phase of a deep-color HDMI link, one step per link clock. At 30, 36 and 48 bits per pixel a pixel does not fill a whole number of link clocks. Pixels are sent in groups: 4 pixels in 5 clocks, 2 pixels in 3 clocks, or 1 pixel in 2 clocks. The block keeps a phase counter that moves through one such clock group. It puts the counter back to zero at the first pixel of each video data period, at the first pixel after each period, and at every HSYNC or VSYNC edge. At 24 bits per pixel there is no partial pixel, and the phase stays at zero.

The block also keeps the packing-phase field that a General Control Packet carries: the phase of the last clock of the most recent video data period. It also decides whether the link may report "default phase". That holds only when every horizontal timing boundary is a whole multiple of the pixel group for the chosen depth. For interlaced timing, half the line total must be a multiple too. The packet builder and the TMDS encoder that sit around this block read these outputs.

Top module: `dcpt_phase_tracker`

## Requirements
- R1: After reset, with the flag inputs low, phase_o is 0, pp_o is 0 and def_phase_o is 0.
- R2: depth_i encodes 0 = 24 bpp, 1 = 30 bpp, 2 = 36 bpp and 3 = 48 bpp. With no restart event, phase_o rises by one on each clock and wraps after 5, 3 or 2 clocks for 30, 36 and 48 bpp.
- R3: At 24 bpp, phase_o is 0 on every clock.
- R4: On the clock where de_i differs from its value on the previous clock (start or end of a data period), phase_o is 0. It then counts 1, 2, ... on the following clocks.
- R5: On the clock where hsync_i or vsync_i differs from its value on the previous clock, phase_o is 0.
- R6: pp_o equals the phase_o of the last clock on which de_i was high. It does not change while de_i is low.
- R7: def_phase_o is 1 one clock after the inputs settle when both of these hold:
  - depth is 30, 36 or 48 bpp;
  - all six horizontal values are multiples of the group size (4 pixels at 30, 2 at 36, 1 at 48).
- R8: If any one of the six horizontal values is not a multiple of the group size, def_phase_o is 0.
- R9: With interlace_i high, def_phase_o also needs h_total_i/2 to be a multiple of the group size.
- R10: At 24 bpp, def_phase_o is 0 whatever the timing values are.
- R11: At 48 bpp the group is one pixel, so any timing values, odd or even, make def_phase_o 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Link clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| depth_i | input | 2 | Colour depth select (0:24, 1:30, 2:36, 3:48 bpp) |
| de_i | input | 1 | Video data period active |
| hsync_i | input | 1 | Horizontal sync level |
| vsync_i | input | 1 | Vertical sync level |
| interlace_i | input | 1 | Interlaced timing |
| h_active_i | input | HW | Active pixels per line |
| h_total_i | input | HW | Total pixels per line |
| h_blank_start_i | input | HW | Blank start pixel |
| h_blank_end_i | input | HW | Blank end pixel |
| h_sync_start_i | input | HW | Sync start pixel |
| h_sync_end_i | input | HW | Sync end pixel |
| phase_o | output | 3 | Current packing phase |
| pp_o | output | 3 | Packing-phase field for control packets |
| def_phase_o | output | 1 | Default phase may be signalled |

## Verification
The hardest case to reach from the ports is a sync edge that falls in the middle of a clock group during blanking, when the counter is neither at zero nor about to wrap. The bench lets the counter run freely at 30 bpp with the data flag low. It then toggles HSYNC and VSYNC on chosen clocks and checks that each edge pulls the phase back to zero. Eligibility is checked with a line total whose quarter is whole but whose half-line is not a multiple of four. Only the interlace rule can then clear the flag.

// File: rtl/dcpt_pkg.sv
package dcpt_pkg;
  localparam int unsigned PHASE_W = 3;

  typedef enum logic [1:0] {
    DEPTH_24 = 2'd0,
    DEPTH_30 = 2'd1,
    DEPTH_36 = 2'd2,
    DEPTH_48 = 2'd3
  } depth_e;

  // link clocks per pixel group
  function automatic logic [PHASE_W-1:0] grp_clks(depth_e d);
    case (d)
      DEPTH_30: grp_clks = 3'd5;
      DEPTH_36: grp_clks = 3'd3;
      DEPTH_48: grp_clks = 3'd2;
      default:  grp_clks = 3'd1;
    endcase
  endfunction

  // low-bit mask for the pixel group size (4, 2 or 1 pixels)
  function automatic logic [1:0] grp_mask(depth_e d);
    case (d)
      DEPTH_30: grp_mask = 2'b11;
      DEPTH_36: grp_mask = 2'b01;
      default:  grp_mask = 2'b00;
    endcase
  endfunction
endpackage

// File: rtl/dcpt_phase_ctr.sv
module dcpt_phase_ctr
  import dcpt_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  depth_e             depth_i,
  input  logic               de_i,
  input  logic               hsync_i,
  input  logic               vsync_i,
  output logic [PHASE_W-1:0] phase_o
);
  logic de_q, hs_q, vs_q;
  logic restart, is_sdr;
  logic [PHASE_W-1:0] len, ph_q, ph_cur, ph_nxt;

  assign len     = grp_clks(depth_i);
  assign is_sdr  = (depth_i == DEPTH_24);
  assign restart = (de_i ^ de_q) | (hsync_i ^ hs_q) | (vsync_i ^ vs_q);
  assign ph_cur  = (restart || is_sdr) ? '0 : ph_q;

  always_comb begin
    if (is_sdr)                        ph_nxt = '0;
    else if (ph_cur >= len - 3'd1)     ph_nxt = '0;
    else                               ph_nxt = ph_cur + 3'd1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      de_q <= 1'b0;
      hs_q <= 1'b0;
      vs_q <= 1'b0;
      ph_q <= '0;
    end else begin
      de_q <= de_i;
      hs_q <= hsync_i;
      vs_q <= vsync_i;
      ph_q <= ph_nxt;
    end
  end

  assign phase_o = ph_cur;

  // R2
  phase_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!is_sdr && $stable(depth_i)) |-> (ph_q < len));
  // R4
  restart_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (restart && !is_sdr) |=> (ph_q == 3'd1));
  // R3
  sdr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_sdr |=> (ph_q == '0));
endmodule

// File: rtl/dcpt_align_chk.sv
module dcpt_align_chk
  import dcpt_pkg::*;
#(
  parameter int unsigned HW     = 13,
  parameter int unsigned N_VALS = 6
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  depth_e                     depth_i,
  input  logic                       interlace_i,
  input  logic [N_VALS-1:0][HW-1:0]  tvals_i,
  input  logic [HW-1:0]              htotal_i,
  output logic                       def_o
);
  logic [1:0]        mask;
  logic [N_VALS-1:0] ok;
  logic              half_ok, elig, def_q;

  assign mask = grp_mask(depth_i);

  for (genvar i = 0; i < N_VALS; i++) begin : g_val
    assign ok[i] = ((tvals_i[i][1:0] & mask) == 2'b00);
  end

  // half line total: bits [2:1] of the total are the low bits of total/2
  assign half_ok = !interlace_i || ((htotal_i[2:1] & mask) == 2'b00);
  assign elig    = (depth_i != DEPTH_24) && (&ok) && half_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) def_q <= 1'b0;
    else         def_q <= elig;
  end

  assign def_o = def_q;

  // R10
  sdr_no_def_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (depth_i == DEPTH_24) |=> !def_q);
endmodule

// File: rtl/dcpt_phase_tracker.sv
module dcpt_phase_tracker
  import dcpt_pkg::*;
#(
  parameter int unsigned HW = 13
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [1:0]         depth_i,
  input  logic               de_i,
  input  logic               hsync_i,
  input  logic               vsync_i,
  input  logic               interlace_i,
  input  logic [HW-1:0]      h_active_i,
  input  logic [HW-1:0]      h_total_i,
  input  logic [HW-1:0]      h_blank_start_i,
  input  logic [HW-1:0]      h_blank_end_i,
  input  logic [HW-1:0]      h_sync_start_i,
  input  logic [HW-1:0]      h_sync_end_i,
  output logic [PHASE_W-1:0] phase_o,
  output logic [PHASE_W-1:0] pp_o,
  output logic               def_phase_o
);
  localparam int unsigned N_VALS = 6;

  depth_e                    depth;
  logic [N_VALS-1:0][HW-1:0] tvals;
  logic [PHASE_W-1:0]        phase, pp_q;

  assign depth = depth_e'(depth_i);
  assign tvals = {h_sync_end_i, h_sync_start_i, h_blank_end_i,
                  h_blank_start_i, h_total_i, h_active_i};

  dcpt_phase_ctr u_ctr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .depth_i (depth),
    .de_i    (de_i),
    .hsync_i (hsync_i),
    .vsync_i (vsync_i),
    .phase_o (phase)
  );

  dcpt_align_chk #(.HW(HW), .N_VALS(N_VALS)) u_align (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .depth_i     (depth),
    .interlace_i (interlace_i),
    .tvals_i     (tvals),
    .htotal_i    (h_total_i),
    .def_o       (def_phase_o)
  );

  // packing-phase field: phase of the last active clock
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   pp_q <= '0;
    else if (de_i) pp_q <= phase;
  end

  assign phase_o = phase;
  assign pp_o    = pp_q;

  // R6
  pp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !de_i |=> $stable(pp_q));
endmodule

// File: tb/dcpt_phase_tracker_bench.sv
module dcpt_phase_tracker_bench;
  localparam int HW = 13;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [1:0]    depth_i = 2'd0;
  logic          de_i = 1'b0, hsync_i = 1'b0, vsync_i = 1'b0, interlace_i = 1'b0;
  logic [HW-1:0] h_active_i = '0, h_total_i = '0, h_blank_start_i = '0;
  logic [HW-1:0] h_blank_end_i = '0, h_sync_start_i = '0, h_sync_end_i = '0;
  logic [2:0]    phase_o, pp_o;
  logic          def_phase_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  dcpt_phase_tracker #(.HW(HW)) u_dcpt_phase_tracker (.*);

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc();
    @(posedge clk_i); #1;
  endtask

  task automatic test_reset();
    #2;
    check("R1 phase", phase_o, 0);
    check("R1 pp", pp_o, 0);
    check("R1 def", def_phase_o, 0);
    cyc(); rst_ni = 1'b1; cyc(); #2;
    check("R1 phase after release", phase_o, 0);
    check("R1 pp after release", pp_o, 0);
    check("R1 def after release", def_phase_o, 0);
    cyc();
  endtask

  // one data period of n clocks at a depth whose group is len clocks
  task automatic test_period(logic [1:0] d, int n, int len, string req);
    depth_i = d; de_i = 1'b0;
    repeat (3) cyc();
    for (int k = 0; k < n; k++) begin
      de_i = 1'b1; #2;
      check({req, " R4 phase in period"}, phase_o, k % len);
      cyc();
    end
    de_i = 1'b0; #2;
    check("R4 phase at period end", phase_o, 0);
    check("R6 pp after period", pp_o, (n - 1) % len);
    cyc();
    for (int k = 0; k < 3; k++) begin
      #2;
      check("R6 pp held in blanking", pp_o, (n - 1) % len);
      if (len == 1) check("R3 phase in blanking", phase_o, 0);
      cyc();
    end
  endtask

  task automatic test_sync();
    depth_i = 2'd1; de_i = 1'b0;
    repeat (2) cyc();
    hsync_i = 1'b1; #2; check("R5 hsync rise", phase_o, 0); cyc();
    #2; check("R2 step after hsync", phase_o, 1); cyc();
    #2; check("R2 step two", phase_o, 2); cyc();
    vsync_i = 1'b1; #2; check("R5 vsync rise", phase_o, 0); cyc();
    #2; check("R2 step after vsync", phase_o, 1); cyc();
    hsync_i = 1'b0; #2; check("R5 hsync fall", phase_o, 0); cyc();
    for (int k = 1; k < 7; k++) begin
      #2; check("R2 free run wrap 5", phase_o, k % 5); cyc();
    end
    vsync_i = 1'b0; #2; check("R5 vsync fall", phase_o, 0); cyc();
  endtask

  task automatic set_timing(int act, int tot, int bs, int be, int ss, int se);
    h_active_i = act[HW-1:0]; h_total_i = tot[HW-1:0];
    h_blank_start_i = bs[HW-1:0]; h_blank_end_i = be[HW-1:0];
    h_sync_start_i = ss[HW-1:0]; h_sync_end_i = se[HW-1:0];
  endtask

  task automatic test_def(logic [1:0] d, logic il, int exp, string req);
    depth_i = d; interlace_i = il;
    cyc(); #2;
    check(req, def_phase_o, exp);
    cyc();
  endtask

  task automatic test_align();
    // total 2204: multiple of 4, half 1102 is not
    set_timing(1920, 2204, 1920, 2204, 2008, 2052);
    test_def(2'd1, 1'b0, 1, "R7 aligned 30bpp");
    test_def(2'd2, 1'b0, 1, "R7 aligned 36bpp");
    test_def(2'd0, 1'b0, 0, "R10 24bpp aligned");
    test_def(2'd1, 1'b1, 0, "R9 interlace half not x4");
    test_def(2'd2, 1'b1, 1, "R9 interlace half even at 36");
    set_timing(1920, 2204, 1920, 2204, 2010, 2052);
    test_def(2'd1, 1'b0, 0, "R8 sync start off by 2 at 30");
    test_def(2'd2, 1'b0, 1, "R7 sync start even at 36");
    set_timing(1920, 2204, 1920, 2204, 2008, 2053);
    test_def(2'd2, 1'b0, 0, "R8 odd sync end at 36");
    set_timing(1921, 2201, 1923, 2201, 2009, 2053);
    test_def(2'd3, 1'b1, 1, "R11 odd values at 48");
    test_def(2'd0, 1'b0, 0, "R10 24bpp odd values");
    set_timing(1920, 2204, 1921, 2204, 2008, 2052);
    test_def(2'd2, 1'b0, 0, "R8 odd blank start at 36");
  endtask

  initial begin
    test_reset();
    test_period(2'd1, 7, 5, "R2 30bpp");
    test_period(2'd2, 7, 3, "R2 36bpp");
    test_period(2'd3, 4, 2, "R2 48bpp");
    test_period(2'd0, 6, 1, "R3 24bpp");
    test_sync();
    test_align();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule